// File: doc/BRIEF.md
# Invalidate/Update Completion Tracker

This block follows one invalidate or update request from the cycle the processor places it on the system bus until the request is finished. While the request is pending it holds the pipeline stall. The external agent finishes the request with a one-cycle acknowledge pulse, which means success, or a one-cycle error pulse. It can also finish it by presenting an external request that cancels it. In that case the block pulses replay so that the instruction that started the request runs again.

An external request whose keep flag is set does not cancel the pending request. The tracker records that such a request is being serviced and keeps the stall raised. When the service-complete strobe arrives, the tracker goes back to plain waiting. From there a later cancelling request, an acknowledge or an error can still end the wait. The acknowledge and error inputs are valid at any time, including while an external request is in service.

Top module: `ivu_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, stall_o, replay_o, done_o, fail_o and viol_o are all 0.
- R2: An issue_i pulse while nothing is pending raises stall_o from the next cycle on. stall_o stays high until the request completes or is cancelled.
- R3: An acknowledge (ack_i=1, err_i=0) while a request is pending, whether waiting or in service, lowers stall_o and pulses done_o for exactly one cycle in the next cycle. It gives no replay.
- R4: An error (err_i=1) while a request is pending lowers stall_o and pulses fail_o for exactly one cycle in the next cycle. It gives no replay.
- R5: An external request with xreq_keep_i=0 (the command's no-cancel bit, bit 4, clear) while waiting lowers stall_o and pulses replay_o for exactly one cycle in the next cycle.
- R6: An external request with xreq_keep_i=1 while waiting keeps stall_o high. Until xreq_done_i arrives, further external requests are ignored. After xreq_done_i the tracker waits again and can be cancelled.
- R7: When ack_i or err_i coincides with a cancelling external request, the completion wins and replay_o stays 0.
- R8: ack_i or err_i while nothing is pending, including the cycle of issue_i itself, pulses viol_o for one cycle. It leaves done_o and fail_o at 0 and does not affect the issue.
- R9: ack_i and err_i together while a request is pending complete it as an error, so fail_o pulses, and also pulse viol_o.
- R10: issue_i while a request is already pending is ignored, and stall_o stays high.
- R11: External requests and xreq_done_i while nothing is pending are ignored: no replay and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Invalidate/update request issued this cycle |
| ack_i | input | 1 | Successful completion pulse from the external agent |
| err_i | input | 1 | Error completion pulse from the external agent |
| xreq_valid_i | input | 1 | Decoded external request accepted this cycle |
| xreq_keep_i | input | 1 | No-cancel flag of that request (1 = pending request kept) |
| xreq_done_i | input | 1 | Servicing of the kept external request has finished |
| stall_o | output | 1 | Pipeline stall, high while a request is pending |
| replay_o | output | 1 | One-cycle pulse: re-execute the originating instruction |
| done_o | output | 1 | One-cycle pulse: request acknowledged |
| fail_o | output | 1 | One-cycle pulse: request completed with error |
| viol_o | output | 1 | One-cycle pulse: completion signalling broke the protocol |

## Verification
Two events can arrive in the same cycle: a completion pulse and a cancelling external request. The expected result is that the completion decides the outcome and no replay is raised. The bench reaches this case, together with an issue arriving alongside a completion, by sweeping all 64 combinations of the six inputs from each of the three tracker conditions: idle, waiting and in service. For each combination it works out the expected stall and pulse outputs one cycle later. In the cycle after that it checks that every pulse has dropped back to 0.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_SVC  = 2'd2
   } ivt_state_e;

   typedef struct packed {
      logic cancel;
      logic keep;
   } xreq_ev_t;

   localparam int unsigned PULSE_W = 4;

endpackage

// File: rtl/ivt_xdecode.sv
module ivt_xdecode
   import ivt_pkg::*;
#(
   parameter bit KEEP_POL = 1'b1
) (
   input  logic     valid_i,
   input  logic     keep_i,
   output xreq_ev_t ev_o
);

   logic keep_raw;

   generate
      if (KEEP_POL) begin : g_pos
         assign keep_raw = keep_i;
      end else begin : g_neg
         assign keep_raw = ~keep_i;
      end
   endgenerate

   always_comb begin
      ev_o.keep   = valid_i &  keep_raw;
      ev_o.cancel = valid_i & ~keep_raw;
   end

endmodule

// File: rtl/ivt_fsm.sv
module ivt_fsm
   import ivt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       issue_i,
   input  logic       ack_i,
   input  logic       err_i,
   input  xreq_ev_t   ev_i,
   input  logic       xdone_i,
   output ivt_state_e st_o,
   output logic       done_ev_o,
   output logic       fail_ev_o,
   output logic       replay_ev_o,
   output logic       viol_ev_o
);

   ivt_state_e st, nxt;
   logic       comp;

   assign comp = ack_i | err_i;

   always_comb begin
      nxt         = st;
      done_ev_o   = 1'b0;
      fail_ev_o   = 1'b0;
      replay_ev_o = 1'b0;
      viol_ev_o   = 1'b0;
      unique case (st)
         ST_IDLE: begin
            viol_ev_o = comp;
            if (issue_i) nxt = ST_WAIT;
         end
         ST_WAIT, ST_SVC: begin
            if (comp) begin
               nxt       = ST_IDLE;
               done_ev_o = ack_i & ~err_i;
               fail_ev_o = err_i;
               viol_ev_o = ack_i & err_i;
            end else if (st == ST_WAIT) begin
               if (ev_i.cancel) begin
                  nxt         = ST_IDLE;
                  replay_ev_o = 1'b1;
               end else if (ev_i.keep) begin
                  nxt = ST_SVC;
               end
            end else if (xdone_i) begin
               nxt = ST_WAIT;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= nxt;
   end

   assign st_o = st;

   // R10
   issue_pending_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && issue_i && !comp && !ev_i.cancel) |=> (st != ST_IDLE));

   // R6
   svc_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SVC && !comp && !xdone_i) |=> (st == ST_SVC));

endmodule

// File: rtl/ivt_pulse.sv
module ivt_pulse #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_w
      $error("ivt_pulse: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= d_i;
   end

endmodule

// File: rtl/ivu_tracker.sv
module ivu_tracker
   import ivt_pkg::*;
#(
   parameter bit KEEP_POL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue_i,
   input  logic ack_i,
   input  logic err_i,
   input  logic xreq_valid_i,
   input  logic xreq_keep_i,
   input  logic xreq_done_i,
   output logic stall_o,
   output logic replay_o,
   output logic done_o,
   output logic fail_o,
   output logic viol_o
);

   xreq_ev_t             ev;
   ivt_state_e           st;
   logic                 done_ev, fail_ev, replay_ev, viol_ev;
   logic [PULSE_W-1:0]   pulse_q;

   ivt_xdecode #(.KEEP_POL(KEEP_POL)) u_dec (
      .valid_i (xreq_valid_i),
      .keep_i  (xreq_keep_i),
      .ev_o    (ev)
   );

   ivt_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_i     (issue_i),
      .ack_i       (ack_i),
      .err_i       (err_i),
      .ev_i        (ev),
      .xdone_i     (xreq_done_i),
      .st_o        (st),
      .done_ev_o   (done_ev),
      .fail_ev_o   (fail_ev),
      .replay_ev_o (replay_ev),
      .viol_ev_o   (viol_ev)
   );

   ivt_pulse #(.W(PULSE_W)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({viol_ev, replay_ev, fail_ev, done_ev}),
      .q_o   (pulse_q)
   );

   assign stall_o  = (st != ST_IDLE);
   assign done_o   = pulse_q[0];
   assign fail_o   = pulse_q[1];
   assign replay_o = pulse_q[2];
   assign viol_o   = pulse_q[3];

   // R2
   stall_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall_o) |-> $past(issue_i));

   // R5
   replay_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      replay_o |-> (!stall_o && $past(stall_o)));

   // R8
   viol_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o |-> $past(ack_i || err_i));

   // R3
   outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({done_o, fail_o, replay_o}) <= 1);

   // R4
   stall_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall_o) |-> (done_o || fail_o || replay_o));

endmodule

// File: tb/tb_ivu_tracker.sv
module tb_ivu_tracker;

   logic clk = 1'b0;
   logic rst_n;
   logic issue, ack, err, xv, xkeep, xdone;
   logic stall, replay, done, fail, viol;
   int   nchk = 0;
   int   nfail = 0;

   always #4 clk = ~clk;

   ivu_tracker dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .issue_i      (issue),
      .ack_i        (ack),
      .err_i        (err),
      .xreq_valid_i (xv),
      .xreq_keep_i  (xkeep),
      .xreq_done_i  (xdone),
      .stall_o      (stall),
      .replay_o     (replay),
      .done_o       (done),
      .fail_o       (fail),
      .viol_o       (viol)
   );

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle_in();
      issue = 0; ack = 0; err = 0; xv = 0; xkeep = 0; xdone = 0;
   endtask

   task automatic do_reset();
      idle_in();
      rst_n = 1'b0;
      step();
      step();
      rst_n = 1'b1;
      step();
   endtask

   function automatic string tag_of(int s, logic i, logic a, logic e, logic v, logic k);
      if (s == 0 && v) return "R11";
      if (s == 0 && (a || e)) return "R8";
      if (s == 0) return "R2";
      if (a && e) return "R9";
      if ((a || e) && v && !k && s == 1) return "R7";
      if (s == 2) return "R6";
      if (i) return "R10";
      if (a) return "R3";
      if (e) return "R4";
      return "R5";
   endfunction

   initial begin
      #1_200_000;
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      idle_in();
      rst_n = 1'b0;
      #2;
      // R1 during reset
      chk("R1", "stall in reset", stall, 1'b0);
      chk("R1", "replay in reset", replay, 1'b0);
      step();
      rst_n = 1'b1;
      step();
      chk("R1", "stall after reset", stall, 1'b0);
      chk("R1", "done after reset", done, 1'b0);
      chk("R1", "fail after reset", fail, 1'b0);
      chk("R1", "viol after reset", viol, 1'b0);

      for (int s = 0; s < 3; s++) begin
         for (int c = 0; c < 64; c++) begin
            logic i, a, e, v, k, d, comp;
            logic x_stall, x_rep, x_done, x_fail, x_viol;
            int   nxt;
            string t;
            do_reset();
            if (s >= 1) begin
               issue = 1; step(); idle_in();
            end
            if (s == 2) begin
               xv = 1; xkeep = 1; step(); idle_in();
            end
            i = c[0]; a = c[1]; e = c[2]; v = c[3]; k = c[4]; d = c[5];
            issue = i; ack = a; err = e; xv = v; xkeep = k; xdone = d;
            step();
            idle_in();
            comp = a | e;
            x_rep = 0; x_done = 0; x_fail = 0; x_viol = 0;
            if (s == 0) begin
               x_viol = comp;
               nxt = i ? 1 : 0;
            end else if (comp) begin
               x_done = a & ~e;
               x_fail = e;
               x_viol = a & e;
               nxt = 0;
            end else if (s == 1) begin
               if (v && !k) begin x_rep = 1; nxt = 0; end
               else if (v) nxt = 2;
               else nxt = 1;
            end else begin
               nxt = d ? 1 : 2;
            end
            x_stall = (nxt != 0);
            t = tag_of(s, i, a, e, v, k);
            chk(t, "stall", stall, x_stall);
            chk(t, "replay", replay, x_rep);
            chk(t, "done", done, x_done);
            chk(t, "fail", fail, x_fail);
            chk(t, "viol", viol, x_viol);
            step();
            chk(t, "stall held", stall, x_stall);
            chk(t, "replay one cycle", replay, 1'b0);
            chk(t, "done one cycle", done, 1'b0);
            chk(t, "fail one cycle", fail, 1'b0);
            chk(t, "viol one cycle", viol, 1'b0);
            if (nxt == 1) begin
               // R6 / R5: back in waiting, a cancel must still work
               xv = 1; xkeep = 0; step(); idle_in();
               chk("R5", "replay after re-wait", replay, 1'b1);
               chk("R5", "stall after re-wait cancel", stall, 1'b0);
            end else if (nxt == 2) begin
               // R6: a further request during service is ignored
               xv = 1; xkeep = 0; step(); idle_in();
               chk("R6", "replay during service", replay, 1'b0);
               chk("R6", "stall during service", stall, 1'b1);
               ack = 1; step(); idle_in();
               chk("R3", "done from service", done, 1'b1);
               chk("R3", "stall after ack in service", stall, 1'b0);
            end
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule